// File: doc/BRIEF.md
# Variable-Precision Array Multiplier

This block multiplies two unsigned 24-bit mantissas in a carry-save array and returns the upper 24 bits of the 48-bit product. Each operand has its own run-time precision, which is the number of its most significant bits that take part in the product. For every low-order multiplicand bit that is switched off, the diagonal slice of partial-product cells fed by that bit is forced to zero. For every low-order multiplier bit that is switched off, the whole row of cells fed by that bit is forced to zero. A forced cell gives a zero partial product and a zero carry. In this model, forcing cells to zero stands in for cutting their supply. The final carry-propagate adder that merges the sum and carry vectors always runs at full width.

A caller presents both operands and both precisions together with a one-cycle start strobe. The operands and precisions are registered on that edge. The product is registered on the next edge and flagged by `done`. A new operation, with new precisions, may start on every cycle. Only the lowest 16 bits of each operand can be switched off, so a precision request below 8 acts as 8 and a request above 24 acts as 24.

Top module: `varprec_array_mult`

## Requirements
- R1: `prod_hi` equals bits 47..24 of the product of the two operands after the disabled low bits of each operand have been cleared.
- R2: When the multiplicand precision is Pa, multiplicand bits 0 to 23-Pa have no effect on the result.
- R3: When the multiplier precision is Pb, multiplier bits 0 to 23-Pb have no effect on the result.
- R4: The two precisions are independent. A reduced multiplicand precision combined with a multiplier at 24 bits, and the reverse, give the result defined in R1.
- R5: Precision inputs are 5-bit unsigned values. A value below 8 acts as 8, and a value above 24 acts as 24.
- R6: `done` is high in the cycle that follows the second rising edge counted from the edge that samples `start`. It stays high for exactly one cycle per start.
- R7: Each operation uses the precisions sampled with its own `start`. Starts on consecutive cycles give results on consecutive cycles, with no interference between them.
- R8: In a cycle where `done` is low, `prod_hi` keeps its previous value.
- R9: While reset is asserted, and after reset until the first result, `done` is 0 and `prod_hi` is 0.
- R10: At precision 24 on both operands, the result is the exact upper half of the full 48-bit product, including for all-ones operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Samples operands and precisions for one operation |
| mcand | input | 24 | Multiplicand |
| mplier | input | 24 | Multiplier |
| prec_mcand | input | 5 | Multiplicand precision in bits |
| prec_mplier | input | 5 | Multiplier precision in bits |
| prod_hi | output | 24 | Upper half of the product |
| done | output | 1 | One-cycle flag: prod_hi holds a new result |

## Verification
If a diagonal or row enable is decoded wrongly, the result of an operation whose cleared bits were nonzero is wrong. That error appears at `prod_hi` in the same cycle as `done` for that operation, two edges after start. A stage-one register that carries values from one operation into the next shows up as a wrong result in back-to-back starts that use different precisions. A faulty carry in the array or in the final adder shows up in the all-ones and random full-precision cases. A faulty valid path shows up as `done` pulsing one cycle early or late, or staying high, in the very next cycle that is compared.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

   // one-bit full adder, returned as {carry, sum}
   function automatic logic [1:0] fa(input logic x, input logic y, input logic z);
      return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
   endfunction

   // bound a requested precision to the controllable range
   function automatic int bound_prec(input int req, input int lo, input int hi);
      if (req < lo) return lo;
      if (req > hi) return hi;
      return req;
   endfunction

endpackage

// File: rtl/vpm_prec_mask.sv
module vpm_prec_mask #(
   parameter int W        = 24,
   parameter int MIN_PREC = 8,
   parameter int PW       = 5
) (
   input  logic [PW-1:0] prec,
   output logic [W-1:0]  keep
);
   import vpm_pkg::*;

   localparam int CTRL = W - MIN_PREC;

   int eff;
   always_comb eff = bound_prec(int'(prec), MIN_PREC, W);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= CTRL) begin : g_fixed
         assign keep[i] = 1'b1;
      end else begin : g_ctrl
         assign keep[i] = (i >= (W - eff));
      end
   end

endmodule

// File: rtl/vpm_csa_array.sv
module vpm_csa_array #(
   parameter int W = 24
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic [W-1:0]   en_a,
   input  logic [W-1:0]   en_b,
   output logic [2*W-1:0] sum_v,
   output logic [2*W-1:0] car_v
);
   import vpm_pkg::*;

   localparam int PWID = 2 * W;

   logic [W:0][PWID-1:0] s_r;
   logic [W:0][PWID-1:0] c_r;
   logic [W-1:0][PWID-1:0] pp;

   assign s_r[0] = '0;
   assign c_r[0] = '0;

   for (genvar j = 0; j < W; j++) begin : g_row
      // partial products of this row; a diagonal enable (en_a) and a row enable (en_b)
      for (genvar k = 0; k < PWID; k++) begin : g_pp
         if (k >= j && k - j < W) begin : g_cell
            assign pp[j][k] = a[k-j] & b[j] & en_a[k-j] & en_b[j];
         end else begin : g_pad
            assign pp[j][k] = 1'b0;
         end
      end
      assign c_r[j+1][0] = 1'b0;
      for (genvar k = 0; k < PWID; k++) begin : g_fa
         logic [1:0] r;
         assign r = fa(s_r[j][k], c_r[j][k], pp[j][k]);
         assign s_r[j+1][k] = r[0];
         if (k < PWID - 1) begin : g_cup
            assign c_r[j+1][k+1] = r[1];
         end
      end
   end

   assign sum_v = s_r[W];
   assign car_v = c_r[W];

endmodule

// File: rtl/vpm_ripple_add.sv
module vpm_ripple_add #(
   parameter int N = 48
) (
   input  logic [N-1:0] x,
   input  logic [N-1:0] y,
   output logic [N-1:0] s
);
   import vpm_pkg::*;

   logic [N:0] cy;
   assign cy[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_stage
      logic [1:0] r;
      assign r       = fa(x[i], y[i], cy[i]);
      assign s[i]    = r[0];
      assign cy[i+1] = r[1];
   end

endmodule

// File: rtl/varprec_array_mult.sv
module varprec_array_mult #(
   parameter int W        = 24,
   parameter int MIN_PREC = 8,
   parameter int PW       = $clog2(W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [W-1:0]  mcand,
   input  logic [W-1:0]  mplier,
   input  logic [PW-1:0] prec_mcand,
   input  logic [PW-1:0] prec_mplier,
   output logic [W-1:0]  prod_hi,
   output logic          done
);

   localparam int PWID = 2 * W;

   if (MIN_PREC < 1 || MIN_PREC > W) begin : g_bad_min
      $error("MIN_PREC must lie in 1..W");
   end
   if ((1 << PW) <= W) begin : g_bad_pw
      $error("PW too narrow to encode W");
   end

   logic [W-1:0] keep_a, keep_b;

   vpm_prec_mask #(.W(W), .MIN_PREC(MIN_PREC), .PW(PW)) i_mask_a (
      .prec(prec_mcand), .keep(keep_a));
   vpm_prec_mask #(.W(W), .MIN_PREC(MIN_PREC), .PW(PW)) i_mask_b (
      .prec(prec_mplier), .keep(keep_b));

   // stage 1: operands and enables
   logic [W-1:0] a_q, b_q, ea_q, eb_q;
   logic         v1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q  <= '0;
         b_q  <= '0;
         ea_q <= '0;
         eb_q <= '0;
         v1_q <= 1'b0;
      end else begin
         v1_q <= start;
         if (start) begin
            a_q  <= mcand;
            b_q  <= mplier;
            ea_q <= keep_a;
            eb_q <= keep_b;
         end
      end
   end

   logic [PWID-1:0] sum_v, car_v, full;

   vpm_csa_array #(.W(W)) i_array (
      .a(a_q), .b(b_q), .en_a(ea_q), .en_b(eb_q),
      .sum_v(sum_v), .car_v(car_v));

   vpm_ripple_add #(.N(PWID)) i_cpa (
      .x(sum_v), .y(car_v), .s(full));

   // stage 2: result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_hi <= '0;
         done    <= 1'b0;
      end else begin
         done <= v1_q;
         if (v1_q) prod_hi <= full[PWID-1:W];
      end
   end

   p_start_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> ##2 done);
   p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(v1_q));
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(prod_hi));
   p_diag_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ((mcand & keep_a) == '0)) |-> ##2 (prod_hi == '0));
   p_row_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ((mplier & keep_b) == '0)) |-> ##2 (prod_hi == '0));

endmodule

// File: tb/test_varprec_array_mult.sv
`timescale 1ns/1ps
module test_varprec_array_mult;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] mcand = '0, mplier = '0;
   logic [4:0]  prec_mcand = 5'd24, prec_mplier = 5'd24;
   logic [23:0] prod_hi;
   logic        done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // model state
   bit          m1_v = 0, m2_v = 0;
   logic [23:0] m1_val = '0, m2_prod = '0;

   always #2.5 clk = ~clk;

   varprec_array_mult i_varprec_array_mult (
      .clk(clk), .rst_n(rst_n), .start(start),
      .mcand(mcand), .mplier(mplier),
      .prec_mcand(prec_mcand), .prec_mplier(prec_mplier),
      .prod_hi(prod_hi), .done(done));

   function automatic logic [23:0] ref_mul(input logic [23:0] a, input logic [23:0] b,
                                           input int pa, input int pb);
      int ea = (pa < 8) ? 8 : ((pa > 24) ? 24 : pa);
      int eb = (pb < 8) ? 8 : ((pb > 24) ? 24 : pb);
      longint am = (longint'(a) >> (24 - ea)) << (24 - ea);
      longint bm = (longint'(b) >> (24 - eb)) << (24 - eb);
      longint p  = am * bm;
      return 24'(p >> 24);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one clock cycle: drive at negedge, update model at posedge, compare at next negedge
   task automatic cyc(input string tag, input bit st, input logic [23:0] a,
                      input logic [23:0] b, input int pa, input int pb);
      start = st; mcand = a; mplier = b;
      prec_mcand = 5'(pa); prec_mplier = 5'(pb);
      @(posedge clk);
      if (m1_v) m2_prod = m1_val;
      m2_v   = m1_v;
      m1_v   = st;
      if (st) m1_val = ref_mul(a, b, pa, pb);
      @(negedge clk);
      check({tag, " R6 done"}, {31'd0, done}, {31'd0, m2_v});
      check({tag, " result"}, {8'd0, prod_hi}, {8'd0, m2_prod});
   endtask

   task automatic idle(input string tag, input int n);
      for (int i = 0; i < n; i++) cyc(tag, 0, 24'($urandom), 24'($urandom), 3, 30);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset done", {31'd0, done}, 32'd0);
      check("R9 reset prod", {8'd0, prod_hi}, 32'd0);
      rst_n = 1'b1;
      idle("R9 post-reset", 2);

      // R10 full precision, all ones and random
      cyc("R10 ones", 1, 24'hFFFFFF, 24'hFFFFFF, 24, 24);
      cyc("R10 one", 1, 24'h800000, 24'h000001, 24, 24);
      idle("R10 drain", 2);
      for (int i = 0; i < 20; i++) cyc("R1 R10 rand", 1, 24'($urandom), 24'($urandom), 24, 24);
      idle("R8 hold", 4);

      // R2 multiplicand reduced, multiplier full (R4)
      for (int p = 8; p <= 24; p++) cyc("R2 R4 mcand", 1, 24'($urandom), 24'($urandom), p, 24);
      cyc("R2 low bits only", 1, 24'h0000FF, 24'hFFFFFF, 8, 24);
      idle("R2 drain", 2);
      // R3 multiplier reduced, multiplicand full (R4)
      for (int p = 8; p <= 24; p++) cyc("R3 R4 mplier", 1, 24'($urandom), 24'($urandom), 24, p);
      cyc("R3 low bits only", 1, 24'hFFFFFF, 24'h00FFFF, 24, 8);
      idle("R3 drain", 2);

      // R4 mixed precisions
      for (int i = 0; i < 30; i++)
         cyc("R4 mixed", 1, 24'($urandom), 24'($urandom), 8 + int'($urandom % 17), 8 + int'($urandom % 17));

      // R5 out-of-range requests
      cyc("R5 zero", 1, 24'hFFFFFF, 24'hFFFFFF, 0, 0);
      cyc("R5 three", 1, 24'hABCDEF, 24'h123456, 3, 7);
      cyc("R5 high", 1, 24'hABCDEF, 24'h123456, 31, 25);
      cyc("R5 mix", 1, 24'hFEDCBA, 24'h987654, 31, 2);
      idle("R5 drain", 3);

      // R7 alternating precisions back to back, with gaps (R8)
      for (int i = 0; i < 16; i++)
         cyc("R7 b2b", 1, 24'hFFFFFF, 24'hFFFFFF, (i % 2) ? 8 : 24, (i % 2) ? 24 : 9);
      for (int i = 0; i < 12; i++)
         cyc("R7 R8 gaps", (i % 3) == 0, 24'($urandom), 24'($urandom), 12, 20);
      idle("final drain", 4);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule